// File: doc/BRIEF.md
# Strobe-handshake cascadable FIFO

This block is a first-in first-out buffer of 64 words of 9 bits each. It uses level strobes with ready indications instead of enables and full/empty lines. A writer raises `shift_in` while `in_ready` is high. The buffer takes the word on that clock edge and drops `in_ready` until the strobe returns low. A reader sees `out_ready` high with the oldest word on `dout` and raises `shift_out` to consume it. `out_ready` then falls, and the next word appears only after the strobe returns low.

All of the logic is synchronous to one clock. A word written into an empty buffer moves to the output on its own, with no read strobe. A write held high against a full buffer completes as soon as space frees. Because of these two rules, units can be chained: one stage's `out_ready` drives the next stage's `shift_in`, and the next stage's `in_ready` drives this stage's `shift_out`. The chain then acts as one deeper buffer that keeps word order.

Two occupancy flags are updated only when a strobe falls. `half_full` reports 32 or more words. `almost_fe` reports 8 or fewer, or 56 or more.

Top module: `strobe_fifo`

## Requirements
- R1: Words leave in exactly the order they entered, all 9 bits intact, and at most 64 words are held.
- R2: While `rst_n` is low: `dout` = 0, `in_ready` = 1, `out_ready` = 0, `half_full` = 0, `almost_fe` = 1.
- R3: The word on `din` is taken at a clock edge where `shift_in` and `in_ready` are both high. `in_ready` is low in the following cycle. It returns high one cycle after `shift_in` is seen low, if fewer than 64 words are held.
- R4: With 64 words held, `in_ready` stays low and no word is taken. If `shift_in` is held high, the word on `din` is taken at the first edge where `in_ready` is high again, one cycle after a word leaves.
- R5: A clock edge with `out_ready` and `shift_out` both high consumes the word, and `out_ready` is low in the next cycle. While `out_ready` is high and `shift_out` is low, `dout` does not change.
- R6: At an edge where `shift_in` is seen falling, `half_full` becomes 1 if 32 or more words are held. At an edge where `shift_out` is seen falling, `half_full` becomes 0 if fewer than 32 are held. Nothing else changes it.
- R7: `almost_fe` changes only at an edge where `shift_in` or `shift_out` is seen falling. At such an edge it takes 1 if 8 or fewer or 56 or more words are held, and 0 otherwise.
- R8: A word written into an empty buffer appears on `dout` with `out_ready` high one cycle after the strobe is seen low, with no `shift_out` activity.
- R9: Two units chained ready-to-strobe hold 128 words and deliver them in order.
- R10: Pulling `rst_n` low in mid-stream discards all held words. After release, `out_ready` stays low until a new word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| shift_in | input | 1 | Write strobe, level sampled |
| din | input | 9 | Word to write |
| in_ready | output | 1 | Buffer can take a word |
| shift_out | input | 1 | Read strobe, level sampled |
| out_ready | output | 1 | A word is valid on `dout` |
| dout | output | 9 | Oldest held word |
| half_full | output | 1 | 32 or more words held, updated on strobe falls |
| almost_fe | output | 1 | Near-empty or near-full, updated on strobe falls |

## Verification
The hardest case to reach is a write held against a full buffer. The stimulus must first fill all 64 slots through the handshake. It then raises `shift_in` with a marker word, keeps it high across several idle cycles, and releases one word from the output side. The bench confirms that `in_ready` rises for exactly one cycle and the marker is taken. Draining all 64 words then shows the marker in the last place, with nothing else slipped in. A two-unit chain is filled until the first unit's `in_ready` stays low, which reaches the same full condition at a stage boundary.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef enum logic [1:0] {
        IN_OPEN = 2'd0,
        IN_HOLD = 2'd1,
        IN_FULL = 2'd2
    } in_state_e;

    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_SHOW = 2'd1,
        OUT_HOLD = 2'd2
    } out_state_e;

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
    parameter int DEPTH     = 64,
    parameter int HALF_MARK = 32,
    parameter int LOW_MARK  = 8,
    parameter int HIGH_MARK = 56,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_in,
    input  logic          shift_out,
    input  logic [CW-1:0] fill,
    output logic          half_full,
    output logic          almost_fe
);

    typedef struct packed {
        logic si_prev;
        logic so_prev;
        logic hf;
        logic aef;
    } flag_state_t;

    flag_state_t q, d;

    logic si_fall, so_fall, at_edge;

    always_comb begin
        d       = q;
        si_fall = q.si_prev && !shift_in;
        so_fall = q.so_prev && !shift_out;
        at_edge = (fill <= CW'(LOW_MARK)) || (fill >= CW'(HIGH_MARK));
        d.si_prev = shift_in;
        d.so_prev = shift_out;
        if (si_fall && fill >= CW'(HALF_MARK)) begin
            d.hf = 1'b1;
        end
        if (so_fall && fill < CW'(HALF_MARK)) begin
            d.hf = 1'b0;
        end
        if (si_fall || so_fall) begin
            d.aef = at_edge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{si_prev: 1'b0, so_prev: 1'b0, hf: 1'b0, aef: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign half_full = q.hf;
    assign almost_fe = q.aef;

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int WIDTH     = 9,
    parameter int DEPTH     = 64,
    parameter int HALF_MARK = 32,
    parameter int LOW_MARK  = 8,
    parameter int HIGH_MARK = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    output logic             out_ready,
    output logic [WIDTH-1:0] dout,
    output logic             half_full,
    output logic             almost_fe
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        in_state_e        in_st;
        out_state_e       out_st;
        logic [AW-1:0]    wr_ptr;
        logic [AW-1:0]    rd_ptr;
        logic [CW-1:0]    count;
        logic [WIDTH-1:0] dout;
    } core_state_t;

    core_state_t q, d;

    logic             accept, consume;
    logic [WIDTH-1:0] head_word;
    logic [CW-1:0]    fill_level;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        accept  = (q.in_st == IN_OPEN) && shift_in;
        consume = (q.out_st == OUT_SHOW) && shift_out;

        if (accept) begin
            d.wr_ptr = next_ptr(q.wr_ptr);
        end
        if (consume) begin
            d.rd_ptr = next_ptr(q.rd_ptr);
        end
        d.count = q.count + CW'(accept) - CW'(consume);

        unique case (q.in_st)
            IN_OPEN: begin
                if (accept) begin
                    d.in_st = IN_HOLD;
                end
            end
            IN_HOLD: begin
                if (!shift_in) begin
                    d.in_st = (d.count == CW'(DEPTH)) ? IN_FULL : IN_OPEN;
                end
            end
            IN_FULL: begin
                if (q.count < CW'(DEPTH)) begin
                    d.in_st = IN_OPEN;
                end
            end
            default: d.in_st = IN_OPEN;
        endcase

        unique case (q.out_st)
            OUT_IDLE: begin
                if (q.count != '0) begin
                    d.out_st = OUT_SHOW;
                    d.dout   = head_word;
                end
            end
            OUT_SHOW: begin
                if (consume) begin
                    d.out_st = OUT_HOLD;
                end
            end
            OUT_HOLD: begin
                if (!shift_out) begin
                    if (q.count != '0) begin
                        d.out_st = OUT_SHOW;
                        d.dout   = head_word;
                    end else begin
                        d.out_st = OUT_IDLE;
                    end
                end
            end
            default: d.out_st = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{in_st: IN_OPEN, out_st: OUT_IDLE, wr_ptr: '0,
                   rd_ptr: '0, count: '0, dout: '0};
        end else begin
            q <= d;
        end
    end

    sfifo_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (q.wr_ptr),
        .wr_data (din),
        .rd_addr (q.rd_ptr),
        .rd_data (head_word)
    );

    sfifo_flags #(
        .DEPTH     (DEPTH),
        .HALF_MARK (HALF_MARK),
        .LOW_MARK  (LOW_MARK),
        .HIGH_MARK (HIGH_MARK)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .fill      (q.count),
        .half_full (half_full),
        .almost_fe (almost_fe)
    );

    assign fill_level = q.count;
    assign in_ready   = (q.in_st == IN_OPEN);
    assign out_ready  = (q.out_st == OUT_SHOW);
    assign dout       = q.dout;

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_in,
    input logic             in_ready,
    input logic             shift_out,
    input logic             out_ready,
    input logic [WIDTH-1:0] dout,
    input logic             half_full,
    input logic             almost_fe,
    input logic [CW-1:0]    fill_level
);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= CW'(DEPTH));

    // R3
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && shift_in |=> !in_ready);

    // R4
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> fill_level < CW'(DEPTH));

    // R5
    consume_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready && shift_out |=> !out_ready);

    // R5
    show_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready && !shift_out |=> out_ready && $stable(dout));

    // R6
    hf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(half_full) |-> !$past(shift_in) && $past(shift_in, 2));

    // R6
    hf_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(half_full) |-> !$past(shift_out) && $past(shift_out, 2));

    // R7
    aef_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(almost_fe) || $fell(almost_fe)) |->
            ((!$past(shift_in) && $past(shift_in, 2)) ||
             (!$past(shift_out) && $past(shift_out, 2))));

endmodule

bind strobe_fifo strobe_fifo_chk #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_in   (shift_in),
    .in_ready   (in_ready),
    .shift_out  (shift_out),
    .out_ready  (out_ready),
    .dout       (dout),
    .half_full  (half_full),
    .almost_fe  (almost_fe),
    .fill_level (fill_level)
);

// File: tb/test_strobe_fifo.sv
module test_strobe_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       si = 1'b0, so = 1'b0;
    logic [8:0] din = '0;
    logic       ir, orr, hf, aef;
    logic [8:0] dout;

    logic       c_si = 1'b0, b_so = 1'b0;
    logic [8:0] c_din = '0;
    logic       a_ir, a_or, b_ir, b_or;
    logic [8:0] a_dout, b_dout;
    logic       a_hf, a_aef, b_hf, b_aef;

    int n_tests = 0, n_fail = 0;
    logic [8:0] q[$];
    bit m_hf, m_aef;

    always #4 clk = ~clk;

    strobe_fifo i_strobe_fifo (
        .clk(clk), .rst_n(rst_n), .shift_in(si), .din(din), .in_ready(ir),
        .shift_out(so), .out_ready(orr), .dout(dout),
        .half_full(hf), .almost_fe(aef));

    strobe_fifo i_casc_a (
        .clk(clk), .rst_n(rst_n), .shift_in(c_si), .din(c_din), .in_ready(a_ir),
        .shift_out(b_ir), .out_ready(a_or), .dout(a_dout),
        .half_full(a_hf), .almost_fe(a_aef));

    strobe_fifo i_casc_b (
        .clk(clk), .rst_n(rst_n), .shift_in(a_or), .din(a_dout), .in_ready(b_ir),
        .shift_out(b_so), .out_ready(b_or), .dout(b_dout),
        .half_full(b_hf), .almost_fe(b_aef));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit edge_zone(input int n);
        return (n <= 8) || (n >= 56);
    endfunction

    task automatic check_flags(input string tag);
        chk(hf == m_hf, {tag, " R6 half_full"}, int'(hf), int'(m_hf));
        chk(aef == m_aef, {tag, " R7 almost_fe"}, int'(aef), int'(m_aef));
    endtask

    task automatic push(input logic [8:0] v);
        while (!ir) @(negedge clk);
        si = 1'b1; din = v;
        @(negedge clk);
        chk(ir == 1'b0, "R3 in_ready low after accept", int'(ir), 0);
        si = 1'b0;
        q.push_back(v);
        @(negedge clk);
        if (q.size() >= 32) m_hf = 1'b1;
        m_aef = edge_zone(q.size());
        check_flags("push");
        chk(ir == (q.size() < 64), "R3 in_ready back after strobe low", int'(ir), int'(q.size() < 64));
    endtask

    task automatic pop();
        logic [8:0] e;
        while (!orr) @(negedge clk);
        e = q.pop_front();
        chk(dout == e, "R1 order", int'(dout), int'(e));
        so = 1'b1;
        @(negedge clk);
        chk(orr == 1'b0, "R5 out_ready low after consume", int'(orr), 0);
        so = 1'b0;
        @(negedge clk);
        if (q.size() < 32) m_hf = 1'b0;
        m_aef = edge_zone(q.size());
        check_flags("pop");
    endtask

    task automatic gap();
        repeat ($urandom_range(0, 3)) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(ir == 1'b1, "R2 in_ready", int'(ir), 1);
        chk(orr == 1'b0, "R2 out_ready", int'(orr), 0);
        chk(dout == '0, "R2 dout", int'(dout), 0);
        chk(hf == 1'b0, "R2 half_full", int'(hf), 0);
        chk(aef == 1'b1, "R2 almost_fe", int'(aef), 1);
    endtask

    task automatic t_fall_through();
        push(9'h1A5);
        chk(orr == 1'b1, "R8 out_ready without read", int'(orr), 1);
        chk(dout == 9'h1A5, "R8 word on dout", int'(dout), 'h1A5);
        repeat (3) @(negedge clk);
        chk(orr == 1'b1 && dout == 9'h1A5, "R5 word held while idle", int'(dout), 'h1A5);
        pop();
        repeat (3) @(negedge clk);
        chk(orr == 1'b0, "R8 empty after pop", int'(orr), 0);
    endtask

    task automatic t_full_hold();
        for (int i = 0; i < 64; i++) begin
            push(9'((i * 37 + 5) % 512));
            gap();
        end
        repeat (4) @(negedge clk);
        chk(ir == 1'b0, "R4 in_ready low when full", int'(ir), 0);
        si = 1'b1; din = 9'h155;
        repeat (5) @(negedge clk);
        chk(ir == 1'b0, "R4 held strobe ignored while full", int'(ir), 0);
        pop();
        chk(ir == 1'b1, "R4 in_ready returns after word leaves", int'(ir), 1);
        @(negedge clk);
        chk(ir == 1'b0, "R4 held word taken", int'(ir), 0);
        si = 1'b0;
        q.push_back(9'h155);
        repeat (2) @(negedge clk);
        chk(ir == 1'b0, "R4 full again", int'(ir), 0);
        while (q.size() > 0) begin
            pop();
            gap();
        end
        repeat (4) @(negedge clk);
        chk(orr == 1'b0, "R1 nothing extra held", int'(orr), 0);
        chk(ir == 1'b1, "R3 in_ready when empty", int'(ir), 1);
    endtask

    task automatic t_random_mix();
        for (int i = 0; i < 300; i++) begin
            if (q.size() == 0 || (q.size() < 64 && $urandom_range(0, 1) == 1))
                push(9'($urandom_range(0, 511)));
            else
                pop();
            gap();
        end
        while (q.size() > 0) pop();
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 5; i++) push(9'(100 + i));
        rst_n = 1'b0;
        @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        q.delete();
        m_hf = 1'b0; m_aef = 1'b1;
        repeat (4) @(negedge clk);
        chk(orr == 1'b0, "R10 contents discarded", int'(orr), 0);
        push(9'h0F0);
        pop();
    endtask

    task automatic t_cascade();
        logic [8:0] cq[$];
        for (int i = 0; i < 128; i++) begin
            while (!a_ir) @(negedge clk);
            c_si = 1'b1; c_din = 9'((i * 53 + 11) % 512);
            cq.push_back(c_din);
            @(negedge clk);
            c_si = 1'b0;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk(a_ir == 1'b0, "R9 chain holds 128", int'(a_ir), 0);
        chk(b_or == 1'b1, "R9 tail stage ready", int'(b_or), 1);
        for (int i = 0; i < 128; i++) begin
            logic [8:0] e;
            while (!b_or) @(negedge clk);
            e = cq.pop_front();
            chk(b_dout == e, "R9 chain order", int'(b_dout), int'(e));
            b_so = 1'b1;
            @(negedge clk);
            b_so = 1'b0;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        chk(b_or == 1'b0, "R9 chain drained", int'(b_or), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_hf = 1'b0; m_aef = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_fall_through();
        t_full_hold();
        t_random_mix();
        t_mid_reset();
        t_cascade();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule